// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the device side of an 8-bit bus on which address and data take turns on the same lines. It sits in front of a 128-byte storage space. Every access comes in two phases. First comes an address phase: the master presents the address and pulses an address strobe, and the block keeps the seven low bits when that strobe falls. Then comes a data phase, in which a read or a write strobe moves one byte. A strobe-style input picks one of two conventions. With `style_i` high, a single data strobe is paired with a direction line. With `style_i` low, the data phase uses separate active-low read and write strobes. If the pin is left unconnected, the integrating level must tie it low.

Every strobe, the chip select, the style input and the power-fail input first pass through a two-flop synchronizer in the system clock domain. Edges are then found on the synchronized copies. Read data and the bus output enable come from registers. The integrating level uses `bus_oe_o` to control the pad buffers. A rising edge on the address strobe wipes out the held address, whatever the chip-select level. A data phase that follows such a rise without a new falling edge does nothing. While power-fail is high, the block accepts no writes and drives no reads.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `bus_oe_o` is 0, `bus_o` is 0 and every storage byte reads back as 0.
- R2: On a falling edge of `as_i`, the block takes `bus_i[6:0]` as the address and marks it valid. `bus_i[7]` is ignored, so address 0x85 selects byte 0x05.
- R3: A rising edge of `as_i` marks the address invalid, whatever the level of `cs_n_i`. Until the next falling edge, a data phase neither writes nor drives the bus.
- R4: With `style_i`=1, a falling edge of `strb_a_i` while `strb_b_i`=0 (write direction) stores `bus_i` at the held address.
- R5: With `style_i`=1, while `strb_a_i`=1 and `strb_b_i`=1 (read direction), the block drives the addressed byte with `bus_oe_o`=1. It releases the bus after `strb_a_i` falls.
- R6: With `style_i`=0, a rising edge of `strb_b_i` (active-low write) stores `bus_i` at the held address.
- R7: With `style_i`=0, while `strb_a_i`=0 (active-low read), the block drives the addressed byte. It releases the bus after `strb_a_i` returns high. Whenever `bus_oe_o`=0, `bus_o` is 0.
- R8: A data phase while `cs_n_i`=1 neither changes storage nor drives the bus.
- R9: While `pfail_i`=1, reads and writes are both ignored.
- R10: `bus_oe_o` rises on the third rising clock edge at which an asserted read strobe is sampled. It falls on the third edge at which the released strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_i | input | 1 | Strobe convention: 1 = data strobe plus direction, 0 = separate read/write strobes |
| as_i | input | 1 | Address strobe. The falling edge latches the address, the rising edge clears it |
| strb_a_i | input | 1 | Data strobe (style 1) or active-low read (style 0) |
| strb_b_i | input | 1 | Direction, 1 = read (style 1), or active-low write (style 0) |
| cs_n_i | input | 1 | Active-low chip select |
| pfail_i | input | 1 | Power-fail; blocks all accesses while high |
| bus_i | input | 8 | Value on the shared bus lines |
| bus_o | output | 8 | Read data for the shared bus lines |
| bus_oe_o | output | 1 | Pad drive enable for `bus_o` |

## Verification
The hardest case to reach is a data phase that arrives after the address has been wiped out by a fresh address-strobe rise but before any new falling edge. In normal traffic a rise is always followed by a fall. The bench therefore raises the strobe with chip select high, leaves it high, and then runs a complete read phase. It then lowers the strobe to restore normal operation. A behavioural model that works from a delayed history of sampled inputs is compared against the outputs on every cycle. Directed reads confirm the stored bytes in both conventions.

// File: rtl/msb_pkg.sv
package msb_pkg;

  // Indices into the synchronized control vector
  localparam int unsigned IX_AS    = 0;
  localparam int unsigned IX_A     = 1;
  localparam int unsigned IX_B     = 2;
  localparam int unsigned IX_CSN   = 3;
  localparam int unsigned IX_STYLE = 4;
  localparam int unsigned IX_PF    = 5;
  localparam int unsigned CTRL_W   = 6;

  // Read window level for the selected convention
  function automatic logic read_level(input logic style, input logic a, input logic b);
    return style ? (a & b) : ~a;
  endfunction

  // Write commit edge for the selected convention
  function automatic logic write_edge(input logic style,
                                      input logic a_cur, input logic a_prv,
                                      input logic b_cur, input logic b_prv);
    return style ? (a_prv & ~a_cur & ~b_cur) : (~b_prv & b_cur);
  endfunction

endpackage

// File: rtl/msb_sync.sv
module msb_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] st [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else if (g == 0) st[g] <= d_i;
        else st[g] <= st[g-1];
      end
    end
  endgenerate

  assign cur_o = st[STAGES-1];
  assign prv_o = st[STAGES];
endmodule

// File: rtl/msb_decode.sv
module msb_decode
  import msb_pkg::*;
(
  input  logic [CTRL_W-1:0] cur_i,
  input  logic [CTRL_W-1:0] prv_i,
  output logic              as_rise_o,
  output logic              as_fall_o,
  output logic              rd_lvl_o,
  output logic              wr_ev_o
);
  logic style;
  assign style     = cur_i[IX_STYLE];
  assign as_rise_o = cur_i[IX_AS] & ~prv_i[IX_AS];
  assign as_fall_o = ~cur_i[IX_AS] & prv_i[IX_AS];
  assign rd_lvl_o  = read_level(style, cur_i[IX_A], cur_i[IX_B]);
  assign wr_ev_o   = write_edge(style, cur_i[IX_A], prv_i[IX_A],
                                cur_i[IX_B], prv_i[IX_B]);
endmodule

// File: rtl/msb_store.sv
module msb_store #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import msb_pkg::*;
#(
  parameter int unsigned AW     = 7,
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          style_i,
  input  logic          as_i,
  input  logic          strb_a_i,
  input  logic          strb_b_i,
  input  logic          cs_n_i,
  input  logic          pfail_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_cur, ctrl_prv;
  logic              as_rise, as_fall, rd_lvl, wr_ev;
  logic              addr_valid, cs_s, pf_s, rd_ok, mem_we;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     rd_data;

  always_comb begin
    ctrl_raw           = '0;
    ctrl_raw[IX_AS]    = as_i;
    ctrl_raw[IX_A]     = strb_a_i;
    ctrl_raw[IX_B]     = strb_b_i;
    ctrl_raw[IX_CSN]   = cs_n_i;
    ctrl_raw[IX_STYLE] = style_i;
    ctrl_raw[IX_PF]    = pfail_i;
  end

  msb_sync #(.W(CTRL_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctrl_raw), .cur_o(ctrl_cur), .prv_o(ctrl_prv)
  );

  msb_decode u_dec (
    .cur_i(ctrl_cur), .prv_i(ctrl_prv),
    .as_rise_o(as_rise), .as_fall_o(as_fall), .rd_lvl_o(rd_lvl), .wr_ev_o(wr_ev)
  );

  assign cs_s   = ~ctrl_cur[IX_CSN];
  assign pf_s   = ctrl_cur[IX_PF];
  assign rd_ok  = rd_lvl & addr_valid & cs_s & ~pf_s;
  assign mem_we = wr_ev & addr_valid & cs_s & ~pf_s;

  msb_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .addr_i(addr_q),
    .wdata_i(bus_i), .rdata_o(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      addr_valid <= 1'b0;
      bus_oe_o   <= 1'b0;
      bus_o      <= '0;
    end else begin
      if (as_rise) begin
        addr_q     <= '0;
        addr_valid <= 1'b0;
      end else if (as_fall) begin
        addr_q     <= bus_i[AW-1:0];
        addr_valid <= 1'b1;
      end
      bus_oe_o <= rd_ok;
      bus_o    <= rd_ok ? rd_data : '0;
    end
  end
endmodule

// File: rtl/msb_checker.sv
module msb_checker #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_i,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          addr_valid,
  input logic [AW-1:0] addr_q,
  input logic          as_rise,
  input logic          as_fall,
  input logic          pf_s,
  input logic          mem_we
);
  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    as_fall |=> (addr_valid && addr_q == $past(bus_i[AW-1:0]))); // R2
  AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    as_rise |=> !addr_valid); // R3
  AST_DRIVE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(addr_valid)); // R3
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_o == '0); // R7
  AST_PFAIL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> !bus_oe_o); // R9
  AST_STORE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> addr_valid); // R8
endmodule

bind mux_bus_slave msb_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
  .addr_valid(addr_valid), .addr_q(addr_q), .as_rise(as_rise), .as_fall(as_fall),
  .pf_s(pf_s), .mem_we(mem_we)
);

// File: tb/sim_mux_bus_slave.sv
`timescale 1ns/1ps
module sim_mux_bus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic style = 1'b1, as_s = 1'b0, sa = 1'b0, sb = 1'b1, csn = 1'b1, pf = 1'b0;
  logic [7:0] bus = 8'h00;
  logic [7:0] dout;
  logic oe;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  mux_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .style_i(style), .as_i(as_s), .strb_a_i(sa),
    .strb_b_i(sb), .cs_n_i(csn), .pfail_i(pf), .bus_i(bus),
    .bus_o(dout), .bus_oe_o(oe)
  );

  // Behavioural reference: history of sampled controls, two-deep sync delay
  logic [5:0] hist[$];
  logic [7:0] m_mem [128];
  logic [6:0] m_addr;
  bit         m_valid;
  logic       exp_oe;
  logic [7:0] exp_do;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {6'd0, 6'd0, 6'd0, 6'd0};
      foreach (m_mem[i]) m_mem[i] = 8'h00;
      m_addr = 0; m_valid = 0; exp_oe = 0; exp_do = 0;
    end else begin
      logic [5:0] c, p;
      bit rd, wr, ok_c;
      hist.push_front({pf, style, csn, sb, sa, as_s});
      void'(hist.pop_back());
      c = hist[2]; p = hist[3];
      ok_c = !c[3] && !c[5] && m_valid;
      if (c[4]) begin
        rd = c[1] && c[2];
        wr = p[1] && !c[1] && !c[2];
      end else begin
        rd = !c[1];
        wr = !p[2] && c[2];
      end
      exp_oe = rd && ok_c;
      exp_do = exp_oe ? m_mem[m_addr] : 8'h00;
      if (wr && ok_c) m_mem[m_addr] = bus;
      if (c[0] && !p[0]) begin m_valid = 0; m_addr = 0; end
      else if (!c[0] && p[0]) begin m_valid = 1; m_addr = bus[6:0]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (oe !== exp_oe || dout !== exp_do) begin
        miscompares++;
        $display("FAIL R10 cycle model: oe=%0b data=%02h expected oe=%0b data=%02h",
                 oe, dout, exp_oe, exp_do);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_style(input logic s);
    style = s; sa = s ? 1'b0 : 1'b1; sb = 1'b1; csn = 1'b1; tick(5);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus = a; as_s = 1'b1; tick(4);
    as_s = 1'b0; tick(4);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic cs_n);
    addr_phase(a);
    bus = d; csn = cs_n;
    if (style) begin sb = 1'b0; sa = 1'b1; tick(4); sa = 1'b0; tick(4); sb = 1'b1; end
    else begin sb = 1'b0; tick(4); sb = 1'b1; tick(4); end
    csn = 1'b1; tick(2);
  endtask

  task automatic strobe_read(input logic cs_n, input logic [7:0] exp,
                             input bit drive, input string tag);
    bus = 8'h00; csn = cs_n;
    if (style) begin sb = 1'b1; sa = 1'b1; end else sa = 1'b0;
    tick(4);
    check(oe === drive, {tag, " drive"}, oe, drive);
    check(dout === (drive ? exp : 8'h00), {tag, " data"}, dout, drive ? exp : 8'h00);
    sa = style ? 1'b0 : 1'b1; tick(4);
    check(oe === 1'b0, {tag, " release"}, oe, 0);
    csn = 1'b1; tick(2);
  endtask

  task automatic do_read(input logic [7:0] a, input logic cs_n, input logic [7:0] exp,
                         input bit drive, input string tag);
    addr_phase(a);
    strobe_read(cs_n, exp, drive, tag);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check(oe === 1'b0 && dout === 8'h00, "R1 reset outputs", {oe, dout}, 0);
    set_style(1'b1);
    do_read(8'h10, 1'b0, 8'h00, 1, "R1 storage cleared");
    // Data strobe convention
    do_write(8'h10, 8'hA5, 1'b0);
    do_read(8'h10, 1'b0, 8'hA5, 1, "R4 write then R5 read");
    do_write(8'h85, 8'h3C, 1'b0);
    do_read(8'h05, 1'b0, 8'h3C, 1, "R2 bit7 ignored");
    // R10 latency: drive read strobe, watch enable rise on third sampled edge
    addr_phase(8'h10);
    csn = 1'b0; sb = 1'b1; sa = 1'b1;
    tick(2);
    check(oe === 1'b0, "R10 not yet driving", oe, 0);
    tick(1);
    check(oe === 1'b1 && dout === 8'hA5, "R10 driving on third edge", {oe, dout}, 9'h1A5);
    sa = 1'b0; tick(2);
    check(oe === 1'b1, "R10 still driving after release", oe, 1);
    tick(1);
    check(oe === 1'b0, "R10 released on third edge", oe, 0);
    csn = 1'b1; tick(2);
    // R8 chip select high
    do_write(8'h10, 8'h77, 1'b1);
    do_read(8'h10, 1'b1, 8'h00, 0, "R8 read ignored with cs high");
    do_read(8'h10, 1'b0, 8'hA5, 1, "R8 write ignored with cs high");
    // R3 rise clears address even with cs high
    addr_phase(8'h10);
    csn = 1'b1; bus = 8'h10; as_s = 1'b1; tick(5);
    strobe_read(1'b0, 8'h00, 0, "R3 no drive after strobe rise");
    bus = 8'h10; csn = 1'b0; sb = 1'b0; sa = 1'b1; tick(4); bus = 8'h99; sa = 1'b0; tick(4);
    sb = 1'b1; csn = 1'b1;
    as_s = 1'b0; tick(5);
    do_read(8'h10, 1'b0, 8'hA5, 1, "R3 write without address ignored");
    // Separate strobe convention
    set_style(1'b0);
    do_write(8'h7F, 8'h5A, 1'b0);
    do_read(8'h7F, 1'b0, 8'h5A, 1, "R6 write then R7 read");
    do_write(8'h00, 8'hC3, 1'b0);
    do_read(8'h00, 1'b0, 8'hC3, 1, "R7 read low address");
    do_read(8'h10, 1'b0, 8'hA5, 1, "R7 earlier byte kept");
    // R9 power fail
    pf = 1'b1; tick(4);
    do_write(8'h7F, 8'hEE, 1'b0);
    do_read(8'h7F, 1'b0, 8'h00, 0, "R9 read ignored in power fail");
    pf = 1'b0; tick(4);
    do_read(8'h7F, 1'b0, 8'h5A, 1, "R9 write ignored in power fail");
    set_style(1'b1);
    do_read(8'h7F, 1'b0, 8'h5A, 1, "R5 read after style switch");
    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule